// File: doc/BRIEF.md
# Scope Sample Ring Writer

This block turns a stream of ADC sample vectors into fixed-size records and writes them, one after another, into a large circular memory region. Each vector carries forty corrected 16-bit signed channel values and the 8-bit state of the timing lines. The block adds a 64-bit timestamp taken from its own free-running cycle counter, packs everything into a 128-byte record, and presents the record with its address on a valid/ready memory write port.

The write pointer starts at the region base and steps forward by one record for each accepted vector. It returns to the base once the last record slot of the region has been used, and recording never stops. The address of the slot that will receive the next record is always visible on an output, so software can find the newest record: it sits directly below that address or, if that address is the base, in the top slot of the region. If the memory port stalls for so long that a second vector arrives while a record is still waiting, the new vector is discarded and a sticky flag reports the loss.

Top module: `scope_ring_writer`

## Requirements
- R1: After reset, next_addr_o equals the region base (default 0x80000000), mem_valid_o is 0 and overflow_o is 0.
- R2: In a record, channel n (0 to 39) occupies byte offsets 2n and 2n+1 of the 128-byte record, least significant byte first. Byte k of the record is mem_data_o[8k+7:8k], so channel n is mem_data_o[16n+15:16n].
- R3: Bytes 0x50 to 0x57 (mem_data_o[703:640]) hold the timestamp, least significant byte first. The timestamp is a cycle counter that is 0 in the first cycle after reset release and rises by one every cycle. A record carries the counter value from the cycle in which its vector was sampled.
- R4: Byte 0x58 (mem_data_o[711:704]) holds the timing-line state. Bytes 0x59 to 0x7F are written as zero.
- R5: A vector sampled with vec_valid_i while the record slot is free raises mem_valid_o in the next cycle. The address of that record is the value next_addr_o had when the vector was sampled.
- R6: Each accepted vector advances next_addr_o by exactly 128. Without an accepted vector, next_addr_o does not change.
- R7: When the record at base + region size - 128 is accepted, next_addr_o returns to the base. Every record address lies inside the region and is a multiple of 128. The newest stored record is at next_addr_o - 128, or in the top slot when next_addr_o is the base.
- R8: While mem_valid_o is 1 and mem_ready_i is 0, mem_valid_o, mem_addr_o and mem_data_o hold their values.
- R9: A vector that arrives while a record is pending and not accepted in that cycle is discarded. overflow_o becomes 1 and stays 1 until reset, and next_addr_o does not change.
- R10: A vector that arrives in the same cycle as the pending record is accepted is taken. This allows one record per cycle with mem_ready_i held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid_i | input | 1 | A sample vector is present this cycle |
| vec_samples_i | input | 640 | Channel samples, channel n in bits [16n+15:16n] |
| lines_i | input | 8 | Timing-line state belonging to the vector |
| mem_valid_o | output | 1 | A record is offered to memory |
| mem_ready_i | input | 1 | Memory takes the offered record this cycle |
| mem_addr_o | output | 32 | Byte address of the offered record |
| mem_data_o | output | 1024 | Offered record, byte k in bits [8k+7:8k] |
| next_addr_o | output | 32 | Address the next record will be written to |
| overflow_o | output | 1 | Sticky: a vector was lost to back-pressure |

## Verification
A wrong pointer shows on next_addr_o in the cycle right after the vector that caused it. From that point every later record address is wrong as well, so a missed or doubled step, or a wrap at the wrong slot, is caught at the first comparison. A wrong timestamp counter or a misplaced field shows in the first record after reset, because the timestamp there must be exactly zero. A pending-record flag that clears too early or too late shows either as a record that changes under back-pressure or as a missing or extra overflow in the same cycle.

// File: rtl/srw_pkg.sv
package srw_pkg;

  localparam int ADDR_W     = 32;
  localparam int SAMPLE_W   = 16;
  localparam int TS_W       = 64;
  localparam int LINE_W     = 8;
  localparam int REC_BYTES  = 128;
  localparam int REC_OFS_W  = $clog2(REC_BYTES);
  localparam int REC_W      = REC_BYTES * 8;
  localparam int TS_BYTE    = 'h50;
  localparam int LINE_BYTE  = 'h58;

  // byte address of record slot idx
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] idx);
    return base + (idx << REC_OFS_W);
  endfunction

  // slot index following idx in a ring whose top slot is last
  function automatic logic [ADDR_W-1:0] ring_next(input logic [ADDR_W-1:0] idx,
                                                  input logic [ADDR_W-1:0] last);
    return (idx == last) ? '0 : idx + 1'b1;
  endfunction

endpackage

// File: rtl/srw_timebase.sv
module srw_timebase #(
  parameter int TS_W = srw_pkg::TS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts_o
);

  logic [TS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign ts_o = cnt_q;

  assert_ts_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts_o == $past(ts_o) + 1'b1);

endmodule

// File: rtl/srw_record_pack.sv
module srw_record_pack #(
  parameter int NUM_CH = 40
) (
  input  logic [NUM_CH*srw_pkg::SAMPLE_W-1:0] samples_i,
  input  logic [srw_pkg::TS_W-1:0]            ts_i,
  input  logic [srw_pkg::LINE_W-1:0]          lines_i,
  output logic [srw_pkg::REC_W-1:0]           rec_o
);
  import srw_pkg::*;

  localparam int TS_LSB   = TS_BYTE * 8;
  localparam int LINE_LSB = LINE_BYTE * 8;

  // lowest byte address carries the least significant byte of every field
  always_comb begin
    rec_o = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      rec_o[ch*SAMPLE_W +: SAMPLE_W] = samples_i[ch*SAMPLE_W +: SAMPLE_W];
    end
    rec_o[TS_LSB +: TS_W]     = ts_i;
    rec_o[LINE_LSB +: LINE_W] = lines_i;
  end

  always_comb begin
    assert_pad_zero_R4: assert (rec_o[REC_W-1:LINE_LSB+LINE_W] == '0);
  end

endmodule

// File: rtl/srw_wr_pointer.sv
module srw_wr_pointer #(
  parameter logic [srw_pkg::ADDR_W-1:0] BASE    = 32'h8000_0000,
  parameter int unsigned                NUM_REC = 32'h0100_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv_i,
  output logic [srw_pkg::ADDR_W-1:0]  addr_o
);
  import srw_pkg::*;

  localparam int unsigned IDX_W = (NUM_REC > 1) ? $clog2(NUM_REC) : 1;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REC - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR = slot_addr(BASE, LAST_IDX);

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] idx_wide;
  logic [ADDR_W-1:0] idx_succ;

  assign idx_wide = ADDR_W'(idx_q);
  assign idx_succ = ring_next(idx_wide, LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (adv_i) idx_q <= idx_succ[IDX_W-1:0];
  end

  assign addr_o = slot_addr(BASE, idx_wide);

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && (addr_o != TOP_ADDR) |=> addr_o == $past(addr_o) + ADDR_W'(REC_BYTES));
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(addr_o));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && (addr_o == TOP_ADDR) |=> addr_o == BASE);

endmodule

// File: rtl/scope_ring_writer.sv
module scope_ring_writer #(
  parameter int                         NUM_CH       = 40,
  parameter logic [srw_pkg::ADDR_W-1:0] BASE         = 32'h8000_0000,
  parameter longint unsigned            REGION_BYTES = 64'h8000_0000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                vec_valid_i,
  input  logic [NUM_CH*srw_pkg::SAMPLE_W-1:0] vec_samples_i,
  input  logic [srw_pkg::LINE_W-1:0]          lines_i,
  output logic                                mem_valid_o,
  input  logic                                mem_ready_i,
  output logic [srw_pkg::ADDR_W-1:0]          mem_addr_o,
  output logic [srw_pkg::REC_W-1:0]           mem_data_o,
  output logic [srw_pkg::ADDR_W-1:0]          next_addr_o,
  output logic                                overflow_o
);
  import srw_pkg::*;

  localparam int unsigned NUM_REC = 32'(REGION_BYTES / REC_BYTES);
  localparam logic [63:0] END64   = 64'(BASE) + REGION_BYTES;

  logic [TS_W-1:0]   ts;
  logic [REC_W-1:0]  rec_now;
  logic [ADDR_W-1:0] slot_addr_now;

  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REC_W-1:0]  data_q;
  logic              ovf_q;

  // named events for the assertions
  logic mem_fire, slot_free, take_vec, drop_vec;
  assign mem_fire  = pend_q && mem_ready_i;
  assign slot_free = !pend_q || mem_ready_i;
  assign take_vec  = vec_valid_i && slot_free;
  assign drop_vec  = vec_valid_i && !slot_free;

  srw_timebase #(.TS_W(TS_W)) u_timebase (
    .clk   (clk),
    .rst_n (rst_n),
    .ts_o  (ts)
  );

  srw_record_pack #(.NUM_CH(NUM_CH)) u_pack (
    .samples_i (vec_samples_i),
    .ts_i      (ts),
    .lines_i   (lines_i),
    .rec_o     (rec_now)
  );

  srw_wr_pointer #(.BASE(BASE), .NUM_REC(NUM_REC)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (take_vec),
    .addr_o (slot_addr_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else if (take_vec) begin
      pend_q <= 1'b1;
      addr_q <= slot_addr_now;
    end else if (mem_fire) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (take_vec) data_q <= rec_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (drop_vec) ovf_q <= 1'b1;
  end

  assign mem_valid_o = pend_q;
  assign mem_addr_o  = addr_q;
  assign mem_data_o  = data_q;
  assign next_addr_o = slot_addr_now;
  assign overflow_o  = ovf_q;

  assert_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_vec |=> mem_valid_o && (mem_addr_o == $past(next_addr_o)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));
  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_vec |=> overflow_o && $stable(next_addr_o));
  assert_no_overflow_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire && vec_valid_i |=> mem_valid_o);
  assert_addr_in_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> (mem_addr_o >= BASE) && (64'(mem_addr_o) < END64)
                    && (mem_addr_o[REC_OFS_W-1:0] == '0));

endmodule

// File: tb/scope_ring_writer_tb_top.sv
module scope_ring_writer_tb_top;

  localparam int          NCH    = 40;
  localparam logic [31:0] BASE   = 32'h8000_0000;
  localparam longint      REGION = 1024;   // eight record slots

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vec_valid = 1'b0;
  logic [NCH*16-1:0] vec_samples = '0;
  logic [7:0]    lines = '0;
  logic          mem_ready = 1'b1;
  logic          mem_valid_o;
  logic [31:0]   mem_addr_o;
  logic [1023:0] mem_data_o;
  logic [31:0]   next_addr_o;
  logic          overflow_o;

  always #2 clk = ~clk;   // 250 MHz

  scope_ring_writer #(.NUM_CH(NCH), .BASE(BASE), .REGION_BYTES(REGION)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .vec_valid_i   (vec_valid),
    .vec_samples_i (vec_samples),
    .lines_i       (lines),
    .mem_valid_o   (mem_valid_o),
    .mem_ready_i   (mem_ready),
    .mem_addr_o    (mem_addr_o),
    .mem_data_o    (mem_data_o),
    .next_addr_o   (next_addr_o),
    .overflow_o    (overflow_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [1023:0] act, input logic [1023:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // expected record built byte by byte from the layout rules
  function automatic logic [1023:0] build_rec(input logic [NCH*16-1:0] s,
                                              input longint unsigned t, input logic [7:0] l);
    logic [1023:0] r = '0;
    for (int b = 0; b < 128; b++) begin
      logic [7:0] v;
      logic [15:0] w;
      v = 8'h00;
      if (b < 2*NCH) begin
        w = s[16*(b/2) +: 16];
        v = (b % 2 == 0) ? w[7:0] : w[15:8];
      end else if (b >= 'h50 && b < 'h58) begin
        v = 8'(t >> (8*(b - 'h50)));
      end else if (b == 'h58) begin
        v = l;
      end
      r[8*b +: 8] = v;
    end
    return r;
  endfunction

  // reference model
  bit              m_valid;
  longint unsigned m_addr, m_next, m_ts;
  logic [1023:0]   m_rec;
  bit              m_ovf;
  logic [7:0]      m_last_lines;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_addr = 0; m_next = BASE; m_ts = 0; m_rec = '0; m_ovf = 0;
      m_last_lines = 0;
    end else begin
      bit busy;
      busy = m_valid && !mem_ready;
      if (vec_valid && busy) begin
        m_ovf = 1;
      end else if (vec_valid) begin
        m_valid = 1;
        m_addr  = m_next;
        m_rec   = build_rec(vec_samples, m_ts, lines);
        m_last_lines = lines;
        m_next  = m_next + 128;
        if (m_next == BASE + REGION) m_next = BASE;
      end else if (m_valid && mem_ready) begin
        m_valid = 0;
      end
      m_ts = m_ts + 1;
    end
  end

  // behavioural memory
  logic [1023:0] bmem [longint unsigned];
  int n_wr = 0;
  always @(posedge clk) begin
    if (rst_n && mem_valid_o && mem_ready) begin
      bmem[longint'(mem_addr_o)] = mem_data_o;
      n_wr++;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 R10 mem_valid", 1024'(mem_valid_o), 1024'(m_valid));
      chk("R6 R7 next_addr", 1024'(next_addr_o), 1024'(m_next[31:0]));
      chk("R9 overflow", 1024'(overflow_o), 1024'(m_ovf));
      if (m_valid) begin
        chk("R5 record address", 1024'(mem_addr_o), 1024'(m_addr[31:0]));
        chk("R2 channel samples", 1024'(mem_data_o[639:0]), 1024'(m_rec[639:0]));
        chk("R3 timestamp", 1024'(mem_data_o[703:640]), 1024'(m_rec[703:640]));
        chk("R4 lines and padding", 1024'(mem_data_o[1023:704]), 1024'(m_rec[1023:704]));
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<50000", cyc);
      finish_run();
    end
  end

  task automatic fill(input int seed);
    for (int n = 0; n < NCH; n++) vec_samples[16*n +: 16] = 16'(seed*977 + n*131 - 4000);
    lines = 8'(seed*29 + 5);
  endtask

  task automatic step(input bit v, input int seed);
    vec_valid = v;
    if (v) fill(seed);
    @(negedge clk);
    vec_valid = 1'b0;
  endtask

  initial begin
    int wr0;
    longint unsigned newest;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 next_addr at reset", 1024'(next_addr_o), 1024'(BASE));
    chk("R1 mem_valid at reset", 1024'(mem_valid), 1024'(1'b0));
    chk("R1 overflow at reset", 1024'(overflow_o), 1024'(1'b0));
    rst_n = 1'b1;
    // first vector in the first cycle after release: timestamp must be 0
    step(1, 1);
    chk("R3 first timestamp zero", 1024'(mem_data_o[703:640]), 1024'(0));
    chk("R5 first record at base", 1024'(mem_addr_o), 1024'(BASE));
    // spaced vectors, ready high, wrapping the eight-slot ring
    for (int i = 2; i <= 8; i++) begin
      step(1, i);
      step(0, 0);
    end
    chk("R7 pointer wrapped to base", 1024'(next_addr_o), 1024'(BASE));
    step(1, 9);
    step(0, 0);
    chk("R7 record after wrap at base", 1024'(mem_addr_o), 1024'(BASE));
    // back-to-back vectors, one per cycle
    wr0 = n_wr;
    for (int i = 0; i < 12; i++) step(1, 20 + i);
    step(0, 0);
    step(0, 0);
    chk("R10 one record per cycle", 1024'(n_wr - wr0), 1024'(12));
    // stall: record must hold
    mem_ready = 1'b0;
    step(1, 40);
    repeat (5) step(0, 0);
    chk("R8 record held under stall", 1024'(mem_valid_o), 1024'(1'b1));
    mem_ready = 1'b1;
    step(0, 0);
    chk("R8 released after ready", 1024'(mem_valid_o), 1024'(1'b0));
    chk("R9 no overflow yet", 1024'(overflow_o), 1024'(1'b0));
    // overflow: second vector while first is pending
    mem_ready = 1'b0;
    step(1, 50);
    begin
      logic [31:0] na;
      na = next_addr_o;
      step(1, 51);
      chk("R9 overflow set", 1024'(overflow_o), 1024'(1'b1));
      chk("R9 pointer unchanged on drop", 1024'(next_addr_o), 1024'(na));
    end
    mem_ready = 1'b1;
    step(0, 0);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      mem_ready = ($urandom_range(0, 3) != 0);
      step($urandom_range(0, 1) == 1, 100 + i);
    end
    mem_ready = 1'b1;
    repeat (4) step(0, 0);
    chk("R9 overflow still set", 1024'(overflow_o), 1024'(1'b1));
    newest = (next_addr_o == BASE) ? (BASE + REGION - 128) : (longint'(next_addr_o) - 128);
    chk("R7 newest record below next_addr", 1024'(bmem[newest][711:704]), 1024'(m_last_lines));
    finish_run();
  end

  wire mem_valid = mem_valid_o;

endmodule